// File: doc/BRIEF.md
# Binary to canonic signed digit recoder

The block converts a WIDTH-bit binary word into canonic signed digit (CSD) form. This form uses the digits -1, 0 and +1 and has the fewest nonzero digits of any signed-digit form. Each output digit position i carries a sign bit and a data bit. A mode input selects how the word is read. In two's-complement mode the word is signed, and the result uses digit positions 0 to WIDTH-1. In unsigned mode the word is a plain magnitude, and one extra top digit at position WIDTH is needed.

Nonzero digits are not found by rippling one carry through the word. Two short alternating AND/OR chains are evaluated side by side instead. The nonzero flag of each digit is the exclusive-or of the two chain values at that position. The sign of each nonzero digit is the next-higher input bit.

A build parameter selects the chain structure:
- a plain ripple;
- a grouped prefix tree that combines generate/propagate pairs in 4-bit groups.

Both structures give the same outputs. Optional input and output registers set the latency. The default is one output register, so a result appears one clock after its input.

Top module: `csd_recoder`

## Requirements
- R1: Digit i is encoded as {csd_sign_o[i], csd_data_o[i]}: 00 is 0, 01 is +1, 10 is -1. The block never emits 11.
- R2: No two adjacent digit positions are both nonzero.
- R3: With mode_signed_i = 0, the sum over positions 0 to WIDTH of digit_i * 2^i equals the unsigned value of bin_i.
- R4: With mode_signed_i = 0, the sign bits of digit positions WIDTH and WIDTH-1 are 0.
- R5: With mode_signed_i = 1, the following hold:
  - digit position WIDTH is 00;
  - the digits of positions 0 to WIDTH-1 sum, weighted by 2^i, to the two's-complement value of bin_i.
- R6: Every digit matches the carry-recurrence recoder, with these definitions:
  - c_i = x_i·x_{i+1} + (x_i + x_{i+1})·c_{i-1}, with c_{-1} = 0;
  - digit i is nonzero exactly when x_i XOR c_{i-1} is 1;
  - a nonzero digit is negative exactly when x_{i+1} is 1;
  - x_WIDTH is 0 in unsigned mode and x_{WIDTH-1} in signed mode;
  - in unsigned mode, digit WIDTH equals c_{WIDTH-1}.
- R7: The unsigned input 87 recodes to:
  - +1 at position 7;
  - -1 at positions 5, 3 and 0;
  - 0 at all other positions.
- R8: With the default registers, outputs change only on a rising clock edge and show the recoding of the input present before that edge. A synchronous active-low reset clears all outputs to 0.
- R9: The ripple chain build (USE_PREFIX = 0) and the grouped prefix build (USE_PREFIX = 1) give bit-identical outputs for every input and mode.
- R10: In signed mode, the recoding of -X equals the recoding of X with every nonzero digit's sign inverted, for X from -(2^(WIDTH-1)-1) to 2^(WIDTH-1)-1. The input -2^(WIDTH-1) recodes to a single -1 at position WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_signed_i | input | 1 | 1: read bin_i as two's complement; 0: read it as unsigned |
| bin_i | input | WIDTH | Binary word to recode |
| csd_sign_o | output | WIDTH+1 | Sign bit of each digit position |
| csd_data_o | output | WIDTH+1 | Data bit of each digit position |

## Verification
The following properties are checked on every clock at the recoder core:
- the illegal 11 digit code never appears;
- no two adjacent positions are both nonzero;
- the weighted digit sum equals the input value in each mode;
- the top-digit rules hold;
- the registered output follows the core by exactly one cycle.

Some behaviour is visible only in the bench scenarios:
- digit-exact agreement with the carry-recurrence model;
- equality of the ripple and prefix builds;
- the negation symmetry and its single asymmetric boundary word;
- the worked example;
- the reset contents.

The signed mode is swept exhaustively at the default width, while unsigned mode gets random and edge patterns.

// File: rtl/csd_pkg.sv
// Shared types and helpers for the CSD recoder.
// Assumes callers combine pairs in the order (higher span, lower span).
package csd_pkg;

    // Generate/propagate pair for one chain step or a span of steps.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Pair for one bit of a chain: an OR step passes the bit as generate;
    // an AND step passes it as propagate.
    function automatic gp_t bit_gp(input logic x, input logic or_step);
        gp_t r;
        r.g = or_step ? x : 1'b0;
        r.p = or_step ? 1'b1 : x;
        return r;
    endfunction

    // Merge a higher span with the lower span that feeds it.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/csd_hk_ripple.sv
// Ripple build of the two interleaved chains.
// Chain H ORs at even bits and ANDs at odd bits; chain K does the reverse.
// Both chains start from 0 below bit 0. Purely combinational.
module csd_hk_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h,
    output logic [W-1:0] k
);
    logic hb [W];
    logic kb [W];

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic h_prev;
            logic k_prev;
            if (i == 0) begin : g_first
                assign h_prev = 1'b0;
                assign k_prev = 1'b0;
            end else begin : g_rest
                assign h_prev = hb[i-1];
                assign k_prev = kb[i-1];
            end
            if (i % 2 == 0) begin : g_even
                assign hb[i] = x[i] | h_prev;
                assign kb[i] = x[i] & k_prev;
            end else begin : g_odd
                assign hb[i] = x[i] & h_prev;
                assign kb[i] = x[i] | k_prev;
            end
            assign h[i] = hb[i];
            assign k[i] = kb[i];
        end
    endgenerate
endmodule

// File: rtl/csd_hk_prefix.sv
// Grouped prefix build of the H and K chains.
// Each 4-bit group is folded into one generate/propagate pair. A tree of
// depth clog2(W/4) across groups supplies every group's entry value, and
// a 3-step ripple inside each group finishes the bits.
// Assumes W is a multiple of 4 and at least 8.
module csd_hk_prefix
    import csd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h,
    output logic [W-1:0] k
);
    localparam int GROUPS = W / 4;
    localparam int LEVELS = $clog2(GROUPS);

    gp_t hbit [W];
    gp_t kbit [W];
    gp_t htree [LEVELS+1][GROUPS];
    gp_t ktree [LEVELS+1][GROUPS];
    logic hb [W];
    logic kb [W];

    genvar i, j, l;
    generate
        // Per-bit pairs: even bits are OR steps in H and AND steps in K.
        for (i = 0; i < W; i++) begin : g_bitgp
            assign hbit[i] = bit_gp(x[i], (i % 2) == 0);
            assign kbit[i] = bit_gp(x[i], (i % 2) == 1);
        end

        // Fold each 4-bit group into one pair.
        for (j = 0; j < GROUPS; j++) begin : g_group
            assign htree[0][j] = gp_merge(gp_merge(hbit[4*j+3], hbit[4*j+2]),
                                          gp_merge(hbit[4*j+1], hbit[4*j]));
            assign ktree[0][j] = gp_merge(gp_merge(kbit[4*j+3], kbit[4*j+2]),
                                          gp_merge(kbit[4*j+1], kbit[4*j]));
        end

        // Prefix tree across groups, doubling the span at each level.
        for (l = 0; l < LEVELS; l++) begin : g_level
            for (j = 0; j < GROUPS; j++) begin : g_node
                if (j >= (1 << l)) begin : g_merge
                    assign htree[l+1][j] = gp_merge(htree[l][j], htree[l][j-(1<<l)]);
                    assign ktree[l+1][j] = gp_merge(ktree[l][j], ktree[l][j-(1<<l)]);
                end else begin : g_pass
                    assign htree[l+1][j] = htree[l][j];
                    assign ktree[l+1][j] = ktree[l][j];
                end
            end
        end

        // Ripple inside each group from the entry value given by the tree.
        for (i = 0; i < W; i++) begin : g_fill
            logic h_prev;
            logic k_prev;
            if (i == 0) begin : g_zero
                assign h_prev = 1'b0;
                assign k_prev = 1'b0;
            end else if (i % 4 == 0) begin : g_entry
                assign h_prev = htree[LEVELS][i/4-1].g;
                assign k_prev = ktree[LEVELS][i/4-1].g;
            end else begin : g_inner
                assign h_prev = hb[i-1];
                assign k_prev = kb[i-1];
            end
            assign hb[i] = hbit[i].g | (hbit[i].p & h_prev);
            assign kb[i] = kbit[i].g | (kbit[i].p & k_prev);
            assign h[i]  = hb[i];
            assign k[i]  = kb[i];
        end
    endgenerate
endmodule

// File: rtl/csd_digit_map.sv
// Turns the chain values into signed digits.
// The nonzero flag is h XOR k. A nonzero digit is negative when the
// next-higher input bit is set; x_ext stands in for the bit above the top.
// The extra top digit equals the last carry, which is derived from the top
// input bit and the top flag, so no explicit carry exists. Combinational.
module csd_digit_map #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic         x_ext,
    input  logic         mode_signed,
    input  logic [W-1:0] h,
    input  logic [W-1:0] k,
    output logic [W:0]   sgn,
    output logic [W:0]   dat
);
    logic [W-1:0] nz;
    logic [W-1:0] above;

    assign nz    = h ^ k;
    assign above = {x_ext, x[W-1:1]};

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_dig
            assign dat[i] = nz[i] & ~above[i];
            assign sgn[i] = nz[i] &  above[i];
        end
    endgenerate

    // Top digit: last carry in unsigned mode, always zero in signed mode.
    assign dat[W] = ~mode_signed & x[W-1] & ~nz[W-1];
    assign sgn[W] = 1'b0;
endmodule

// File: rtl/csd_recoder.sv
// Binary to CSD recoder top.
// It optionally registers the input, builds the H/K chains (ripple or
// grouped prefix, chosen by USE_PREFIX), maps them to digits and
// optionally registers the output. Latency is REG_IN + REG_OUT cycles.
// Reset is synchronous and active low. Assumes WIDTH is a multiple of 4,
// from 8 to 64.
module csd_recoder #(
    parameter int WIDTH      = 16,
    parameter bit USE_PREFIX = 1'b0,
    parameter bit REG_IN     = 1'b0,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_signed_i,
    input  logic [WIDTH-1:0] bin_i,
    output logic [WIDTH:0]   csd_sign_o,
    output logic [WIDTH:0]   csd_data_o
);
    localparam int DIGITS = WIDTH + 1;

    logic [WIDTH-1:0]  x_c;
    logic              mode_c;
    logic [WIDTH-1:0]  h_c;
    logic [WIDTH-1:0]  k_c;
    logic [DIGITS-1:0] sgn_c;
    logic [DIGITS-1:0] dat_c;

    generate
        if (REG_IN) begin : g_in_reg
            logic [WIDTH-1:0] x_q;
            logic             mode_q;
            // Capture the input word and mode.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    x_q    <= '0;
                    mode_q <= 1'b0;
                end else begin
                    x_q    <= bin_i;
                    mode_q <= mode_signed_i;
                end
            end
            assign x_c    = x_q;
            assign mode_c = mode_q;
        end else begin : g_in_wire
            assign x_c    = bin_i;
            assign mode_c = mode_signed_i;
        end

        if (USE_PREFIX) begin : g_prefix
            csd_hk_prefix #(.W(WIDTH)) chains_i (.x(x_c), .h(h_c), .k(k_c));
        end else begin : g_ripple
            csd_hk_ripple #(.W(WIDTH)) chains_i (.x(x_c), .h(h_c), .k(k_c));
        end
    endgenerate

    csd_digit_map #(.W(WIDTH)) map_i (
        .x           (x_c),
        .x_ext       (mode_c & x_c[WIDTH-1]),
        .mode_signed (mode_c),
        .h           (h_c),
        .k           (k_c),
        .sgn         (sgn_c),
        .dat         (dat_c)
    );

    generate
        if (REG_OUT) begin : g_out_reg
            // Hold the recoded digits for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    csd_sign_o <= '0;
                    csd_data_o <= '0;
                end else begin
                    csd_sign_o <= sgn_c;
                    csd_data_o <= dat_c;
                end
            end

            // R8: the registered output shows the previous cycle's core result.
            p_out_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (csd_sign_o == $past(sgn_c)) && (csd_data_o == $past(dat_c)));
        end else begin : g_out_wire
            assign csd_sign_o = sgn_c;
            assign csd_data_o = dat_c;
        end
    endgenerate

    // Weighted value of a digit vector, for checking only.
    function automatic logic signed [WIDTH+2:0] digit_sum(
        input logic [DIGITS-1:0] s, input logic [DIGITS-1:0] d);
        logic signed [WIDTH+2:0] acc;
        acc = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (d[i]) acc = acc + (({{(WIDTH+2){1'b0}}, 1'b1}) <<< i);
            if (s[i]) acc = acc - (({{(WIDTH+2){1'b0}}, 1'b1}) <<< i);
        end
        return acc;
    endfunction

    logic signed [WIDTH+2:0] val_c;
    logic signed [WIDTH+2:0] x_uns;
    logic signed [WIDTH+2:0] x_sgn;
    assign val_c = digit_sum(sgn_c, dat_c);
    assign x_uns = {3'b000, x_c};
    assign x_sgn = {{3{x_c[WIDTH-1]}}, x_c};

    p_no_code11_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn_c & dat_c) == '0);

    p_no_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (((sgn_c | dat_c) >> 1) & (sgn_c | dat_c)) == '0);

    p_unsigned_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_c |-> (val_c == x_uns));

    p_unsigned_top_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_c |-> (sgn_c[WIDTH] == 1'b0) && (sgn_c[WIDTH-1] == 1'b0));

    p_signed_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_c |-> (val_c == x_sgn) && !sgn_c[WIDTH] && !dat_c[WIDTH]);
endmodule

// File: tb/csd_recoder_tb.sv
// Directed bench for csd_recoder at WIDTH = 16. The ripple build (dut_i)
// and the prefix build run side by side. Every result is compared with a
// carry-recurrence model written here.
module csd_recoder_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] bin = '0;
    logic [W:0]   sgn_r, dat_r, sgn_p, dat_p;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csd_recoder #(.WIDTH(W), .USE_PREFIX(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_signed_i(mode), .bin_i(bin),
        .csd_sign_o(sgn_r), .csd_data_o(dat_r));

    csd_recoder #(.WIDTH(W), .USE_PREFIX(1'b1)) dut_pfx_i (
        .clk(clk), .rst_n(rst_n), .mode_signed_i(mode), .bin_i(bin),
        .csd_sign_o(sgn_p), .csd_data_o(dat_p));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Carry-recurrence model of the recoder.
    task automatic model(input logic [W-1:0] x, input logic sm,
                         output logic [W:0] ms, output logic [W:0] md);
        logic c;
        logic xe, nxt, dflag;
        c  = 1'b0;
        xe = sm & x[W-1];
        ms = '0;
        md = '0;
        for (int i = 0; i < W; i++) begin
            nxt   = (i == W-1) ? xe : x[i+1];
            dflag = x[i] ^ c;
            md[i] = dflag & ~nxt;
            ms[i] = dflag & nxt;
            c     = (x[i] & nxt) | ((x[i] | nxt) & c);
        end
        if (!sm) md[W] = c;
    endtask

    function automatic longint dsum(input logic [W:0] s, input logic [W:0] d);
        longint a = 0;
        for (int i = 0; i <= W; i++) begin
            if (d[i]) a += (64'sd1 <<< i);
            if (s[i]) a -= (64'sd1 <<< i);
        end
        return a;
    endfunction

    // Apply one word at a falling edge; the result is read at the next
    // falling edge, after the output register has loaded.
    task automatic apply(input logic [W-1:0] x, input logic sm);
        mode = sm;
        bin  = x;
        @(negedge clk);
    endtask

    // Full check of one vector against all requirements.
    task automatic run_vec(input logic [W-1:0] x, input logic sm);
        logic [W:0] ms, md;
        longint expv;
        apply(x, sm);
        model(x, sm, ms, md);
        expv = sm ? longint'($signed(x)) : longint'(x);
        chk((sgn_r & dat_r) == '0, "R1", "code 11", {47'b0, sgn_r & dat_r}, 64'd0);
        chk(((((sgn_r | dat_r) >> 1)) & (sgn_r | dat_r)) == '0, "R2", "adjacent",
            {47'b0, sgn_r | dat_r}, 64'd0);
        if (sm) begin
            chk(dsum(sgn_r, dat_r) == expv, "R5", "signed value", dsum(sgn_r, dat_r), expv);
            chk(!sgn_r[W] && !dat_r[W], "R5", "top digit", {62'b0, sgn_r[W], dat_r[W]}, 64'd0);
        end else begin
            chk(dsum(sgn_r, dat_r) == expv, "R3", "unsigned value", dsum(sgn_r, dat_r), expv);
            chk(!sgn_r[W] && !sgn_r[W-1], "R4", "top signs", {62'b0, sgn_r[W], sgn_r[W-1]}, 64'd0);
        end
        chk(sgn_r == ms && dat_r == md, "R6", "model", {30'b0, sgn_r, dat_r}, {30'b0, ms, md});
        chk(sgn_p == sgn_r && dat_p == dat_r, "R9", "prefix vs ripple",
            {30'b0, sgn_p, dat_p}, {30'b0, sgn_r, dat_r});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        mode  = 1'b0;
        bin   = '1;
        repeat (3) @(negedge clk);
        chk(sgn_r == '0 && dat_r == '0 && sgn_p == '0 && dat_p == '0, "R8", "reset clears",
            {30'b0, sgn_r, dat_r}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_example;
        logic [W:0] es, ed;
        es = '0;
        ed = '0;
        ed[7] = 1'b1;
        es[5] = 1'b1;
        es[3] = 1'b1;
        es[0] = 1'b1;
        apply(16'd87, 1'b0);
        chk(sgn_r == es && dat_r == ed, "R7", "87 recoding", {30'b0, sgn_r, dat_r}, {30'b0, es, ed});
    endtask

    task automatic t_latency;
        logic [W:0] ms, md, os, od;
        apply(16'h0003, 1'b0);
        os = sgn_r;
        od = dat_r;
        mode = 1'b0;
        bin  = 16'h7777;
        #2;
        chk(sgn_r == os && dat_r == od, "R8", "no change before edge",
            {30'b0, sgn_r, dat_r}, {30'b0, os, od});
        @(negedge clk);
        model(16'h7777, 1'b0, ms, md);
        chk(sgn_r == ms && dat_r == md, "R8", "one-cycle result",
            {30'b0, sgn_r, dat_r}, {30'b0, ms, md});
    endtask

    task automatic t_unsigned;
        logic [W-1:0] edges [8] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555,
                                    16'h8000, 16'h0001, 16'h7FFF, 16'hC003};
        foreach (edges[e]) run_vec(edges[e], 1'b0);
        for (int n = 0; n < 20000; n++) run_vec(W'($urandom), 1'b0);
    endtask

    task automatic t_signed_sweep;
        for (int v = 0; v < (1 << W); v++) run_vec(W'(v), 1'b1);
    endtask

    task automatic t_negation;
        logic [W-1:0] vals [6] = '{16'h0001, 16'h0057, 16'h7FFF, 16'h5555, 16'h1234, 16'h0F0F};
        logic [W:0] ps, pd, ns, nd, es;
        foreach (vals[e]) begin
            apply(vals[e], 1'b1);
            ps = sgn_r;
            pd = dat_r;
            apply(W'(-vals[e]), 1'b1);
            ns = sgn_r;
            nd = dat_r;
            chk(ns == pd && nd == ps, "R10", "negation flips signs",
                {30'b0, ns, nd}, {30'b0, pd, ps});
        end
        apply(16'h8000, 1'b1);
        es = '0;
        es[W-1] = 1'b1;
        chk(sgn_r == es && dat_r == '0, "R10", "most negative word",
            {30'b0, sgn_r, dat_r}, {30'b0, es, 17'b0});
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_example();
        t_latency();
        t_negation();
        t_unsigned();
        t_signed_sweep();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule